// File: doc/BRIEF.md
# Fixed-Latency External Bus Slave

This block lets an external microcontroller reach an on-chip register bank through its synchronous, address/data-multiplexed memory controller port. The master frames every access with an active-low chip select. The first clock of an access has the address-latch strobe low as well, and the address is present only in that clock. After that the master follows a fixed timetable. A write places its data on the data lines exactly four clocks after the latch clock. A read lowers output-enable two clocks after the latch clock and samples the data lines some time later. The slave never stretches an access, so its wait output is tied inactive.

The slave does not handshake. It counts clock edges from the latch clock. It latches the address. For a write it takes the data word on the fourth edge and issues a one-clock write strobe on the internal bus one clock later. For a read it issues a one-clock read strobe in the clock straight after the latch. It takes the registered read data one clock after that strobe and presents the word to the pad ring until the access ends. The data pins are split into input, output and output-enable, and the tristate buffer sits in the pad ring. The internal side has no back-pressure: the register bank accepts every strobe, and its read data must follow one clock after the strobe.

Top module: `fixlat_bus_slave`

## Requirements
- R1: A synchronous reset clears both internal strobes, sets the internal address to zero and drops the data output-enable, even in the middle of an access. An access cut short by reset produces no write strobe.
- R2: The wait output is high at all times.
- R3: The internal address equals the address lines as sampled on the edge where chip select and address-latch are both low. The address lines are ignored on every other edge.
- R4: The write data is the value on the data input exactly 4 edges after the latch edge. The data input is ignored on all other edges.
- R5: For a write (write-enable low on the latch edge), the internal write strobe is high for exactly one clock. That clock lies between the 5th and 6th edges after the latch edge, one clock after data capture, and the strobe carries the latched address and the captured data.
- R6: For a read (write-enable high on the latch edge), the internal read strobe is high for exactly one clock, in the clock that follows the latch edge, with the latched address.
- R7: Read data returned one clock after the read strobe is driven on the data output. It holds steady while output-enable stays low, from 3 clocks after the latch to the end of the access.
- R8: The data output-enable is high only while chip select and output-enable are both low during an access that was latched as a read. Output-enable low with no latched read leaves it low.
- R9: Each access produces exactly one strobe of its own kind and none of the other kind.
- R10: Accesses may follow each other with a single idle clock of chip select high, and a read straight after a write to the same address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, shared with the master |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_lat_n | input | 1 | Address-latch strobe, active low |
| bus_we_n | input | 1 | Write-enable, active low |
| bus_oe_n | input | 1 | Output-enable, active low |
| bus_addr | input | 24 | Address lines, valid in the latch clock only |
| bus_dq_i | input | 32 | Data lines as received from the pad |
| bus_dq_o | output | 32 | Read data toward the pad |
| bus_dq_oe | output | 1 | Pad drive enable for bus_dq_o |
| bus_wait_n | output | 1 | Wait output, held high |
| reg_addr | output | 24 | Internal address |
| reg_wr | output | 1 | One-clock internal write strobe |
| reg_wdata | output | 32 | Internal write data |
| reg_rd | output | 1 | One-clock internal read strobe |
| reg_rdata | input | 32 | Registered internal read data, one clock after reg_rd |

## Verification
A wrong edge count inside the sequencer shows up within one access. A write strobe off by one clock, or write data taken from a garbage cycle, shows as a wrong word at reg_wdata six clocks after the latch edge. A read path that captures too early shows the previous word on bus_dq_o by the master's sample point, five clocks after the latch. A stuck read-active flag shows as bus_dq_oe high while output-enable is low with no latched read. A lost reset shows as a stray write strobe within six clocks after the reset is released.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic {
    XFER_RD = 1'b0,
    XFER_WR = 1'b1
  } xfer_kind_t;
endpackage

// File: rtl/fl_seq.sv
// Access sequencer: latches the address and kind, counts edges since latch.
module fl_seq
  import fl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              lat_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              start,
  output logic              active,
  output xfer_kind_t        kind,
  output logic [PH_W-1:0]   phase,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

  assign start = ~cs_n & ~lat_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      kind   <= XFER_RD;
      phase  <= '0;
      addr_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      kind   <= we_n ? XFER_RD : XFER_WR;
      phase  <= PH_W'(1);
      addr_q <= addr;
    end else if (cs_n) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (active && phase != PH_MAX) begin
      phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/fl_wr_path.sv
// Write path: captures data at a fixed edge, strobes one clock later.
module fl_wr_path
  import fl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PH_W      = 3,
  parameter int WR_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              active,
  input  xfer_kind_t        kind,
  input  logic [PH_W-1:0]   phase,
  input  logic [DATA_W-1:0] dq_i,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wdata
);
  logic cap;
  logic pend;

  assign cap = active && !cs_n && kind == XFER_WR && phase == PH_W'(WR_OFFSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      wr_stb <= 1'b0;
      wdata  <= '0;
    end else begin
      pend   <= cap;
      wr_stb <= pend;
      if (cap) wdata <= dq_i;
    end
  end
endmodule

// File: rtl/fl_rd_path.sv
// Read path: strobe right after latch, capture after the source latency, pad drive.
module fl_rd_path #(
  parameter int DATA_W = 32,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rdata,
  output logic              rd_stb,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic [RD_LAT-1:0] pipe;
  logic              rd_active;

  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= rd_stb;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[RD_LAT-2:0], rd_stb};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb    <= 1'b0;
      rd_active <= 1'b0;
      dq_o      <= '0;
    end else begin
      rd_stb <= start & we_n;
      if (start)     rd_active <= we_n;
      else if (cs_n) rd_active <= 1'b0;
      if (pipe[RD_LAT-1]) dq_o <= rdata;
    end
  end

  assign dq_oe = rd_active & ~oe_n & ~cs_n;
endmodule

// File: rtl/fixlat_bus_slave.sv
module fixlat_bus_slave
  import fl_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int WR_OFFSET = 4,
  parameter int RD_LAT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_lat_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_dq_i,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  output logic              bus_wait_n,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int PH_W = $clog2(WR_OFFSET + 2);

  logic            start;
  logic            active;
  xfer_kind_t      kind;
  logic [PH_W-1:0] phase;

  assign bus_wait_n = 1'b1;

  fl_seq #(.ADDR_W(ADDR_W), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .lat_n(bus_lat_n), .we_n(bus_we_n),
    .addr(bus_addr), .start(start), .active(active), .kind(kind),
    .phase(phase), .addr_q(reg_addr)
  );

  fl_wr_path #(.DATA_W(DATA_W), .PH_W(PH_W), .WR_OFFSET(WR_OFFSET)) u_wr (
    .clk(clk), .rst(rst), .cs_n(bus_cs_n), .active(active), .kind(kind),
    .phase(phase), .dq_i(bus_dq_i), .wr_stb(reg_wr), .wdata(reg_wdata)
  );

  fl_rd_path #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst(rst), .start(start), .we_n(bus_we_n), .cs_n(bus_cs_n),
    .oe_n(bus_oe_n), .rdata(reg_rdata), .rd_stb(reg_rd), .dq_o(bus_dq_o),
    .dq_oe(bus_dq_oe)
  );
endmodule

// File: rtl/fixlat_bus_slave_chk.sv
module fixlat_bus_slave_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              lat_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe,
  input logic              wait_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_rd
);
  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (rst) wait_n); // R2
  AST_RD_ADDR: assert property (@(posedge clk) disable iff (rst) reg_rd |-> reg_addr == $past(addr)); // R3
  AST_WR_DATA_MATCH: assert property (@(posedge clk) disable iff (rst) reg_wr |-> reg_wdata == $past(dq_i, 2)); // R4
  AST_WR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R5
  AST_RD_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R6
  AST_RD_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst) reg_rd |-> $past(!cs_n && !lat_n && we_n)); // R6
  AST_DQ_STABLE: assert property (@(posedge clk) disable iff (rst) (dq_oe && $past(dq_oe, 2)) |-> $stable(dq_o)); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(reg_wr && reg_rd)); // R9
endmodule

bind fixlat_bus_slave fixlat_bus_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(bus_cs_n), .lat_n(bus_lat_n), .we_n(bus_we_n),
  .addr(bus_addr), .dq_i(bus_dq_i), .dq_o(bus_dq_o), .dq_oe(bus_dq_oe),
  .wait_n(bus_wait_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rd(reg_rd)
);

// File: tb/fixlat_bus_slave_test.sv
`timescale 1ns / 1ps
module fixlat_bus_slave_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, lat_n, we_n, oe_n;
  logic [23:0] addr;
  logic [31:0] dq_i;
  logic [31:0] dq_o;
  logic        dq_oe, wait_n;
  logic [23:0] reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] src_q;

  logic [31:0] bank  [16];
  logic [31:0] model [16];
  int checks = 0, fails = 0, wr_seen = 0, rd_seen = 0, wr_sent = 0, rd_sent = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fixlat_bus_slave uut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_lat_n(lat_n), .bus_we_n(we_n),
    .bus_oe_n(oe_n), .bus_addr(addr), .bus_dq_i(dq_i), .bus_dq_o(dq_o),
    .bus_dq_oe(dq_oe), .bus_wait_n(wait_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(src_q)
  );

  function automatic logic [31:0] seed(int k);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ (32'(k) << 24);
  endfunction

  // Register bank on the internal side, registered read data
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 16; k++) bank[k] <= seed(k);
      src_q <= '0;
    end else begin
      if (reg_wr) bank[reg_addr[3:0]] <= reg_wdata;
      if (reg_rd) src_q <= bank[reg_addr[3:0]];
      if (reg_wr) wr_seen <= wr_seen + 1;
      if (reg_rd) rd_seen <= rd_seen + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Starts and ends on a falling edge
  task automatic wr_xfer(logic [23:0] a, logic [31:0] d);
    cs_n = 0; lat_n = 0; we_n = 0; addr = a; dq_i = ~d;
    @(negedge clk); lat_n = 1; addr = ~a; dq_i = d ^ 32'h0F0F_0F0F;
    @(negedge clk); dq_i = d + 32'd1;
    @(negedge clk); dq_i = d - 32'd1;
    @(negedge clk); dq_i = d;
    @(negedge clk); cs_n = 1; we_n = 1; dq_i = d ^ 32'h5A5A_5A5A;
    chk(reg_wr == 1'b0, "R5 strobe before capture+1", 32'(reg_wr), 0);
    @(negedge clk);
    chk(reg_wr == 1'b1, "R5 strobe", 32'(reg_wr), 1);
    chk(reg_addr == a, "R3 write address", 32'(reg_addr), 32'(a));
    chk(reg_wdata == d, "R4 write data", reg_wdata, d);
    chk(reg_rd == 1'b0, "R9 no read strobe on write", 32'(reg_rd), 0);
    model[a[3:0]] = d;
    wr_sent++;
  endtask

  task automatic rd_xfer(logic [23:0] a, string tag);
    logic [31:0] e;
    e = model[a[3:0]];
    cs_n = 0; lat_n = 0; we_n = 1; oe_n = 1; addr = a;
    @(negedge clk); lat_n = 1; addr = ~a;
    chk(reg_rd == 1'b1, "R6 read strobe", 32'(reg_rd), 1);
    chk(reg_addr == a, "R3 read address", 32'(reg_addr), 32'(a));
    chk(dq_oe == 1'b0, "R8 no drive while oe high", 32'(dq_oe), 0);
    @(negedge clk); oe_n = 0;
    chk(reg_rd == 1'b0, "R6 single clock", 32'(reg_rd), 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(dq_oe == 1'b1, "R7 drive enable", 32'(dq_oe), 1);
    chk(dq_o == e, {tag, " R7 data at sample"}, dq_o, e);
    chk(wait_n == 1'b1, "R2 wait high", 32'(wait_n), 1);
    @(negedge clk);
    chk(dq_o == e, "R7 data held", dq_o, e);
    @(negedge clk);
    chk(dq_o == e && dq_oe, "R7 data held in turnaround", dq_o, e);
    cs_n = 1; oe_n = 1;
    #1;
    chk(dq_oe == 1'b0, "R8 release on deselect", 32'(dq_oe), 0);
    @(negedge clk);
    rd_sent++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w0;
    rst = 1; cs_n = 1; lat_n = 1; we_n = 1; oe_n = 1; addr = '0; dq_i = '0;
    for (int k = 0; k < 16; k++) model[k] = seed(k);
    repeat (4) @(negedge clk);
    chk(reg_wr == 0 && reg_rd == 0, "R1 strobes after reset", {reg_wr, reg_rd}, 0);
    chk(dq_oe == 0, "R1 bus released", 32'(dq_oe), 0);
    chk(reg_addr == 0, "R1 address cleared", 32'(reg_addr), 0);
    chk(wait_n == 1, "R2 wait high in reset", 32'(wait_n), 1);
    rst = 0;
    @(negedge clk);

    // output-enable low with no latched read
    cs_n = 0; oe_n = 0; #1;
    chk(dq_oe == 0, "R8 no drive without latched read", 32'(dq_oe), 0);
    @(negedge clk); cs_n = 1; oe_n = 1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) rd_xfer({8'(i * 37), 12'(i * 291), 4'(i)}, "seed");
    for (int i = 0; i < 16; i++)
      wr_xfer({8'(i * 11), 12'(i * 7), 4'(i)}, (32'h1357_9BDF * 32'(i + 3)) ^ 32'(i));
    for (int i = 15; i >= 0; i--) rd_xfer({8'hC0 | 8'(i), 12'h0, 4'(i)}, "sweep");
    for (int i = 15; i >= 0; i--) begin
      wr_xfer({8'(255 - i), 12'(i), 4'(i)}, 32'hF00D_0000 + 32'(i * 4099));
      rd_xfer({8'(i), 12'hABC, 4'(i)}, "R10 write then read");
    end

    // reset in the middle of a read drops the drive
    cs_n = 0; lat_n = 0; we_n = 1; addr = 24'h000005;
    @(negedge clk); lat_n = 1;
    @(negedge clk); oe_n = 0;
    @(negedge clk);
    chk(dq_oe == 1, "R7 drive before reset", 32'(dq_oe), 1);
    rst = 1;
    @(negedge clk);
    chk(dq_oe == 0, "R1 reset releases bus", 32'(dq_oe), 0);
    rst = 0; cs_n = 1; oe_n = 1;
    @(negedge clk);

    // reset in the middle of a write suppresses the strobe
    w0 = wr_seen;
    cs_n = 0; lat_n = 0; we_n = 0; addr = 24'h000003;
    @(negedge clk); lat_n = 1;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk); dq_i = 32'hDEAD_BEEF;
    @(negedge clk); cs_n = 1; we_n = 1;
    repeat (3) @(negedge clk);
    chk(wr_seen == w0, "R1 aborted write has no strobe", 32'(wr_seen), 32'(w0));
    for (int k = 0; k < 16; k++) model[k] = seed(k);
    rd_xfer(24'h000003, "R1 bank reset");

    chk(wr_seen == wr_sent, "R9 write strobe count", 32'(wr_seen), 32'(wr_sent));
    chk(rd_seen == rd_sent + 1, "R9 read strobe count", 32'(rd_seen), 32'(rd_sent + 1));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule